// File: doc/BRIEF.md
# Hierarchical Interrupt Pending Controller

This block gathers interrupt events for a multi-mode serial-bus terminal and turns them into one active-high interrupt line and a set of host-readable registers. Thirteen hardware event lines are sampled on every clock. An event is kept only if its enable bit is already set in that cycle. A kept event sets a bit in the hardware pending register. If the output-enable bit for that event is also set when the event is kept, the event is marked high priority and holds the interrupt line high until the host reads the pending register. Pending bits whose output enable was clear stay in the register for the host to poll. They never raise the line.

The three lowest bits of the hardware pending register are not latched. Each one shows, live, whether one of three subordinate pending registers is non-zero. Those subordinate registers sit outside the block. The block reads them through three 16-bit inputs. When the host reads one of them through this block, the block pulses that register's clear strobe. Every pending register clears when the host reads it.

The host port takes an address, a read strobe, a write strobe and 16-bit write data. Read data comes back one cycle after the strobe, together with a valid flag. The port accepts every strobe and has no back-pressure, so the host cannot stall it and must take the read data in the cycle it is flagged valid.

Top module: `irq_hier_ctl`

## Requirements
- R1: After reset, the enable register holds the reset mask (default 0x0007), the output-enable register and every hardware pending bit are 0, and irq_o and host_rvalid_o are low.
- R2: A pulse on event line k (k = 0..12) sets hardware pending bit k+3 only if enable bit k+3 is 1 in the cycle the pulse is sampled. A write to the enable register in that same cycle does not count for that pulse.
- R3: Setting an enable bit from 0 to 1 does not make visible any event that arrived while the bit was 0.
- R4: A read of address 2 (hardware pending) returns the register and clears its bits 15..3 from the next cycle on.
- R5: A pending bit whose output-enable bit was 0 when it was latched can be read, but it does not assert irq_o.
- R6: irq_o is the OR of all qualifying conditions. It is high while any high-priority hardware pending bit remains, and one assertion may cover several simultaneous events. It falls once a read has cleared all of them and no summary condition holds.
- R7: Whether an event is high priority is fixed when the event is latched. Changing the output-enable register afterwards neither raises nor drops irq_o for bits that are already pending.
- R8: If an enabled event and a read of address 2 fall in the same cycle, the read returns the old value and the new event stays pending.
- R9: Pending bits 0, 1 and 2 show live whether the subordinate registers BC, MT and RT, in that order, are non-zero. Each bit is gated by the matching enable bit. These bits are not cleared by a read of address 2. A bit that shows 1 drives irq_o when its output-enable bit is 1.
- R10: A read of address 3, 4 or 5 returns the BC, MT or RT subordinate value. In the cycle the read data is valid, it pulses that register's clear strobe and no other.
- R11: Address 0 (enable) and address 1 (output enable) are read/write. Writes to any other address have no effect. Reads of addresses 6 and 7 return 0.
- R12: host_rvalid_o is high exactly in the cycle after each read strobe, and host_rdata_o is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hw_event_i | input | 13 | Single-cycle hardware event pulses; line k maps to pending bit k+3 |
| sub_bc_pend_i | input | 16 | Current value of the BC subordinate pending register |
| sub_mt_pend_i | input | 16 | Current value of the MT subordinate pending register |
| sub_rt_pend_i | input | 16 | Current value of the RT subordinate pending register |
| sub_bc_clr_o | output | 1 | One-cycle clear request to the BC subordinate register |
| sub_mt_clr_o | output | 1 | One-cycle clear request to the MT subordinate register |
| sub_rt_clr_o | output | 1 | One-cycle clear request to the RT subordinate register |
| host_addr_i | input | 3 | Register address |
| host_rd_i | input | 1 | Read strobe |
| host_wr_i | input | 1 | Write strobe |
| host_wdata_i | input | 16 | Write data |
| host_rdata_o | output | 16 | Read data, valid while host_rvalid_o is high |
| host_rvalid_o | output | 1 | Read data valid, one cycle after a read strobe |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The bench targets the moment an event is judged. It pulses an event in the same cycle an enable write arrives, and it enables a bit after an event was dropped. A design that looked at the new enable value, or kept a record of masked events, would show a pending bit that should be absent. It rewrites the output-enable register after latching, in both directions. A design that computed priority live would raise or drop irq_o when it should not. It puts an event and a clearing read in the same cycle, where a careless clear loses the new event. It also checks that the summary bits survive a read of the hardware pending register and follow the subordinate values until their clear strobes act, which a design that latched the summaries would get wrong.

// File: rtl/irq_hier_pkg.sv
package irq_hier_pkg;
  localparam int unsigned NUM_SUB  = 3;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned SUB_BASE = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_ENABLE = 3'd0,
    SEL_OUTEN  = 3'd1,
    SEL_HWPEND = 3'd2,
    SEL_BCPEND = 3'd3,
    SEL_MTPEND = 3'd4,
    SEL_RTPEND = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned       DATA_W = 16,
  parameter logic [DATA_W-1:0] EN_RST = '0,
  parameter logic [DATA_W-1:0] OE_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_en_i,
  input  logic              we_oe_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] en_o,
  output logic [DATA_W-1:0] oe_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_o <= EN_RST;
      oe_o <= OE_RST;
    end else begin
      if (we_en_i) en_o <= wdata_i;
      if (we_oe_i) oe_o <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_hw_pending.sv
module irq_hw_pending #(
  parameter int unsigned NHW = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NHW-1:0] event_i,
  input  logic [NHW-1:0] en_i,
  input  logic [NHW-1:0] oe_i,
  input  logic           clr_i,
  output logic [NHW-1:0] pend_o,
  output logic [NHW-1:0] hot_o
);
  for (genvar b = 0; b < NHW; b++) begin : g_bit
    logic take;
    // judged against the enable value held before this edge
    assign take = event_i[b] & en_i[b];

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        pend_o[b] <= 1'b0;
        hot_o[b]  <= 1'b0;
      end else begin
        // a new event wins over a clear in the same cycle
        pend_o[b] <= (pend_o[b] & ~clr_i) | take;
        hot_o[b]  <= (hot_o[b] & ~clr_i) | (take & oe_i[b]);
      end
    end
  end
endmodule

// File: rtl/irq_sub_summary.sv
module irq_sub_summary #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_SUB = 3
) (
  input  logic [NUM_SUB*DATA_W-1:0] sub_vec_i,
  output logic [NUM_SUB-1:0]        nz_o
);
  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    assign nz_o[s] = |sub_vec_i[s*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/irq_hier_ctl.sv
module irq_hier_ctl
  import irq_hier_pkg::*;
#(
  parameter int unsigned       DATA_W = 16,
  parameter logic [DATA_W-1:0] EN_RST = 16'h0007,
  parameter logic [DATA_W-1:0] OE_RST = '0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [DATA_W-NUM_SUB-1:0] hw_event_i,
  input  logic [DATA_W-1:0]         sub_bc_pend_i,
  input  logic [DATA_W-1:0]         sub_mt_pend_i,
  input  logic [DATA_W-1:0]         sub_rt_pend_i,
  output logic                      sub_bc_clr_o,
  output logic                      sub_mt_clr_o,
  output logic                      sub_rt_clr_o,
  input  logic [ADDR_W-1:0]         host_addr_i,
  input  logic                      host_rd_i,
  input  logic                      host_wr_i,
  input  logic [DATA_W-1:0]         host_wdata_i,
  output logic [DATA_W-1:0]         host_rdata_o,
  output logic                      host_rvalid_o,
  output logic                      irq_o
);
  localparam int unsigned NHW = DATA_W - NUM_SUB;

  reg_sel_e                  sel;
  logic [DATA_W-1:0]         en_q, oe_q;
  logic [NHW-1:0]            en_hw, oe_hw, pend_q, hot_q;
  logic [NUM_SUB*DATA_W-1:0] sub_vec;
  logic [NUM_SUB-1:0]        sub_nz, sum_vis, sub_hit, clr_q;
  logic                      hw_rd, we_en, we_oe;
  logic [DATA_W-1:0]         rd_mux, rdata_q;
  logic                      rvalid_q;

  assign sel   = reg_sel_e'(host_addr_i);
  assign hw_rd = host_rd_i && (sel == SEL_HWPEND);
  assign we_en = host_wr_i && (sel == SEL_ENABLE);
  assign we_oe = host_wr_i && (sel == SEL_OUTEN);

  assign en_hw = en_q[DATA_W-1:NUM_SUB];
  assign oe_hw = oe_q[DATA_W-1:NUM_SUB];

  // index 0 = BC, 1 = MT, 2 = RT; matches the summary bit positions
  assign sub_vec = {sub_rt_pend_i, sub_mt_pend_i, sub_bc_pend_i};

  irq_cfg_regs #(
    .DATA_W (DATA_W),
    .EN_RST (EN_RST),
    .OE_RST (OE_RST)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_en_i (we_en),
    .we_oe_i (we_oe),
    .wdata_i (host_wdata_i),
    .en_o    (en_q),
    .oe_o    (oe_q)
  );

  irq_hw_pending #(
    .NHW (NHW)
  ) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (hw_event_i),
    .en_i    (en_hw),
    .oe_i    (oe_hw),
    .clr_i   (hw_rd),
    .pend_o  (pend_q),
    .hot_o   (hot_q)
  );

  irq_sub_summary #(
    .DATA_W  (DATA_W),
    .NUM_SUB (NUM_SUB)
  ) u_sum (
    .sub_vec_i (sub_vec),
    .nz_o      (sub_nz)
  );

  assign sum_vis = sub_nz & en_q[NUM_SUB-1:0];

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_hit
    localparam logic [ADDR_W-1:0] SUB_ADDR = ADDR_W'(SUB_BASE + s);
    assign sub_hit[s] = (host_addr_i == SUB_ADDR);
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_ENABLE: rd_mux = en_q;
      SEL_OUTEN:  rd_mux = oe_q;
      SEL_HWPEND: rd_mux = {pend_q, sum_vis};
      default: begin
        for (int s = 0; s < NUM_SUB; s++) begin
          if (sub_hit[s]) rd_mux = sub_vec[s*DATA_W +: DATA_W];
        end
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      clr_q    <= '0;
    end else begin
      rvalid_q <= host_rd_i;
      clr_q    <= host_rd_i ? sub_hit : '0;
      if (host_rd_i) rdata_q <= rd_mux;
    end
  end

  assign host_rdata_o  = rdata_q;
  assign host_rvalid_o = rvalid_q;
  assign sub_bc_clr_o  = clr_q[0];
  assign sub_mt_clr_o  = clr_q[1];
  assign sub_rt_clr_o  = clr_q[2];

  assign irq_o = (|hot_q) | (|(sum_vis & oe_q[NUM_SUB-1:0]));
endmodule

// File: rtl/irq_hier_ctl_chk.sv
module irq_hier_ctl_chk #(
  parameter int unsigned       DATA_W  = 16,
  parameter int unsigned       NUM_SUB = 3,
  parameter logic [DATA_W-1:0] EN_RST  = '0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      rd,
  input logic                      hw_rd,
  input logic [DATA_W-NUM_SUB-1:0] event_v,
  input logic [DATA_W-NUM_SUB-1:0] en_hw,
  input logic [DATA_W-NUM_SUB-1:0] oe_hw,
  input logic [DATA_W-NUM_SUB-1:0] pend,
  input logic [DATA_W-NUM_SUB-1:0] hot,
  input logic [DATA_W-1:0]         en_full,
  input logic [NUM_SUB-1:0]        sub_nz,
  input logic [NUM_SUB-1:0]        clr,
  input logic                      irq,
  input logic                      rvalid
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_full == EN_RST && pend == '0 && !rvalid));

  p_drop_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) & ~$past(en_hw)) == '0);

  p_no_late_recognition_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) & ~$past(event_v)) == '0);

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rd |=> ((pend & ~$past(event_v & en_hw)) == '0));

  p_quiet_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hot == '0 && sub_nz == '0) |-> !irq);

  p_hot_within_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hot & ~pend) == '0);

  p_priority_at_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((hot & ~$past(hot)) & ~$past(oe_hw & event_v)) == '0);

  p_event_survives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_rd && (event_v & en_hw) != '0) |=> (pend != '0));

  p_single_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));

  p_clear_with_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |-> rvalid);

  p_valid_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);

  p_valid_only_after_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid);
endmodule

bind irq_hier_ctl irq_hier_ctl_chk #(
  .DATA_W  (DATA_W),
  .NUM_SUB (NUM_SUB),
  .EN_RST  (EN_RST)
) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .rd      (host_rd_i),
  .hw_rd   (hw_rd),
  .event_v (hw_event_i),
  .en_hw   (en_hw),
  .oe_hw   (oe_hw),
  .pend    (pend_q),
  .hot     (hot_q),
  .en_full (en_q),
  .sub_nz  (sub_nz),
  .clr     (clr_q),
  .irq     (irq_o),
  .rvalid  (host_rvalid_o)
);

// File: tb/irq_hier_ctl_bench.sv
module irq_hier_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] ev = '0;
  logic [15:0] sub_bc = '0, sub_mt = '0, sub_rt = '0;
  logic        clr_bc, clr_mt, clr_rt;
  logic [2:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rvalid, irq;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_hier_ctl u_irq_hier_ctl (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .hw_event_i    (ev),
    .sub_bc_pend_i (sub_bc),
    .sub_mt_pend_i (sub_mt),
    .sub_rt_pend_i (sub_rt),
    .sub_bc_clr_o  (clr_bc),
    .sub_mt_clr_o  (clr_mt),
    .sub_rt_clr_o  (clr_rt),
    .host_addr_i   (addr),
    .host_rd_i     (rd),
    .host_wr_i     (wr),
    .host_wdata_i  (wdata),
    .host_rdata_o  (rdata),
    .host_rvalid_o (rvalid),
    .irq_o         (irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, written from the requirements
  logic [15:0] m_en, m_oe, m_pend, m_hot, m_rdata;
  logic        m_rvalid;
  logic [2:0]  m_clr;

  function automatic logic [2:0] nz_now();
    return {|sub_rt, |sub_mt, |sub_bc};
  endfunction

  always @(posedge clk) begin
    logic [15:0] rv, setv;
    logic        hwclr;
    if (!rst_n) begin
      m_en = 16'h0007; m_oe = '0; m_pend = '0; m_hot = '0;
      m_rdata = '0; m_rvalid = 1'b0; m_clr = '0;
    end else begin
      case (addr)
        3'd0: rv = m_en;
        3'd1: rv = m_oe;
        3'd2: rv = m_pend | {13'b0, nz_now() & m_en[2:0]};
        3'd3: rv = sub_bc;
        3'd4: rv = sub_mt;
        3'd5: rv = sub_rt;
        default: rv = '0;
      endcase
      if (m_clr[0]) sub_bc <= '0;
      if (m_clr[1]) sub_mt <= '0;
      if (m_clr[2]) sub_rt <= '0;
      if (rd) m_rdata = rv;
      m_rvalid = rd;
      m_clr = {rd && addr == 3'd5, rd && addr == 3'd4, rd && addr == 3'd3};
      setv  = {ev, 3'b000} & m_en;
      hwclr = rd && addr == 3'd2;
      m_pend = (hwclr ? 16'h0 : m_pend) | setv;
      m_hot  = (hwclr ? 16'h0 : m_hot) | (setv & m_oe);
      if (wr && addr == 3'd0) m_en = wdata;
      if (wr && addr == 3'd1) m_oe = wdata;
    end
  end

  // per-clock comparison, 2 ns before the rising edge
  always begin
    @(negedge clk);
    #8;
    if (rst_n && !done) begin
      chk("R6", {15'b0, irq},
          {15'b0, (|m_hot) | (|(nz_now() & m_en[2:0] & m_oe[2:0]))});
      chk("R12", {15'b0, rvalid}, {15'b0, m_rvalid});
      chk("R10", {13'b0, clr_rt, clr_mt, clr_bc}, {13'b0, m_clr});
      if (m_rvalid) chk(cur_tag, rdata, m_rdata);
    end
  end

  task automatic cyc(input logic [12:0] e, input logic r, input logic w,
                     input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    ev = e; rd = r; wr = w; addr = a; wdata = d;
    @(negedge clk);
    ev = '0; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    #1;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
    cur_tag = tag;
    cyc('0, 1'b1, 1'b0, a, '0);
    chk(tag, rdata, exp);
    chk("R12", {15'b0, rvalid}, 16'h1);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    cyc('0, 1'b0, 1'b1, a, d);
  endtask

  task automatic pulse(input logic [12:0] e);
    cyc(e, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('0, 1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", {14'b0, irq, rvalid}, 16'h0);
    rd_chk(3'd0, 16'h0007, "R1");
    chk("R12", {15'b0, rvalid}, 16'h1);
    idle(1);
    chk("R12", {15'b0, rvalid}, 16'h0);
    rd_chk(3'd1, 16'h0000, "R1");
    rd_chk(3'd2, 16'h0000, "R1");

    // R2: event while disabled is discarded; R3: enabling later shows nothing
    pulse(13'h0004);
    rd_chk(3'd2, 16'h0000, "R2");
    wr_reg(3'd0, 16'h0027);
    rd_chk(3'd2, 16'h0000, "R3");

    // R5 / R4: low-priority pending, clear on read
    pulse(13'h0004);
    chk("R5", {15'b0, irq}, 16'h0);
    rd_chk(3'd2, 16'h0020, "R4");
    rd_chk(3'd2, 16'h0000, "R4");

    // R6: high priority raises the line, read drops it
    wr_reg(3'd1, 16'h0020);
    pulse(13'h0004);
    chk("R6", {15'b0, irq}, 16'h1);
    rd_chk(3'd2, 16'h0020, "R6");
    chk("R6", {15'b0, irq}, 16'h0);

    // R7: priority fixed at latch time
    wr_reg(3'd1, 16'h0000);
    pulse(13'h0004);
    wr_reg(3'd1, 16'h0020);
    chk("R7", {15'b0, irq}, 16'h0);
    rd_chk(3'd2, 16'h0020, "R7");
    pulse(13'h0004);
    wr_reg(3'd1, 16'h0000);
    chk("R7", {15'b0, irq}, 16'h1);
    rd_chk(3'd2, 16'h0020, "R7");
    chk("R7", {15'b0, irq}, 16'h0);

    // R8: event in the same cycle as the clearing read survives
    wr_reg(3'd0, 16'h0067);
    pulse(13'h0004);
    cur_tag = "R8";
    cyc(13'h0008, 1'b1, 1'b0, 3'd2, '0);
    chk("R8", rdata, 16'h0020);
    rd_chk(3'd2, 16'h0040, "R8");

    // R2: enable write in the same cycle as the event does not count
    cyc(13'h0010, 1'b0, 1'b1, 3'd0, 16'h00E7);
    rd_chk(3'd2, 16'h0000, "R2");
    pulse(13'h0010);
    rd_chk(3'd2, 16'h0080, "R2");

    // R6: several simultaneous events, one line
    wr_reg(3'd1, 16'h00E0);
    pulse(13'h001C);
    chk("R6", {15'b0, irq}, 16'h1);
    rd_chk(3'd2, 16'h00E0, "R6");
    chk("R6", {15'b0, irq}, 16'h0);

    // R9: live summaries of the subordinate registers
    sub_rt = 16'h0100;
    rd_chk(3'd2, 16'h0004, "R9");
    chk("R9", {15'b0, irq}, 16'h0);
    sub_bc = 16'h0001;
    rd_chk(3'd2, 16'h0005, "R9");
    rd_chk(3'd2, 16'h0005, "R9");
    wr_reg(3'd0, 16'h00E6);
    rd_chk(3'd2, 16'h0004, "R9");
    wr_reg(3'd1, 16'h00E4);
    chk("R9", {15'b0, irq}, 16'h1);

    // R10: subordinate read returns its value and strobes its clear
    rd_chk(3'd5, 16'h0100, "R10");
    chk("R10", {13'b0, clr_rt, clr_mt, clr_bc}, 16'h0004);
    idle(2);
    chk("R10", {15'b0, irq}, 16'h0);
    rd_chk(3'd2, 16'h0000, "R10");
    rd_chk(3'd3, 16'h0001, "R10");
    chk("R10", {13'b0, clr_rt, clr_mt, clr_bc}, 16'h0001);
    idle(2);

    // R11: read-only and unmapped addresses
    wr_reg(3'd2, 16'hFFFF);
    rd_chk(3'd2, 16'h0000, "R11");
    wr_reg(3'd7, 16'hFFFF);
    rd_chk(3'd6, 16'h0000, "R11");
    rd_chk(3'd0, 16'h00E6, "R11");
    rd_chk(3'd1, 16'h00E4, "R11");

    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule